// File: doc/BRIEF.md
# Peripheral Window Address Decoder with Test Mode

This block sits between the processor core and the 32-byte peripheral window that starts at address 16'h4000. For each access it works out which window register is addressed and produces an active-low read strobe and an active-low write strobe for it. It also raises a drive enable whenever the data pins must turn into outputs because the chip is answering a read itself. Finally, it selects the byte that the core sees: either an internal register value or whatever is on the external bus.

A test pin changes how the window is classified. With the pin low, the only address the chip answers internally is offset 16'h15. With the pin high, every address in the window is answered internally, and three placeholder test registers become visible at offsets 16'h18 to 16'h1A. One side effect follows from this: the two controller read strobes at offsets 16'h16 and 16'h17 still pulse, but the controller data no longer reaches the core. The controller write port is unaffected by the pin.

The test pin passes through a two-stage inverting conditioner, the same kind used for a reset input, before it reaches the decode.

Top module: `io_window_decode`

## Requirements
- R1: An address outside 16'h4000..16'h401F leaves every bit of `win_rd_n` and `win_wr_n` high and `data_oe` low, and `cpu_rd_data` equals `ext_bus_in`.
- R2: While `phi2` is low, every bit of `win_rd_n` and `win_wr_n` is high and `data_oe` is low, whatever the address.
- R3: In normal mode, a read (`rw`=1) of 16'h4015 with `phi2` high drives `data_oe` high and returns `status_in` on `cpu_rd_data`. No other address drives `data_oe` in normal mode.
- R4: In test mode, a read of any window address with `phi2` high drives `data_oe` high.
- R5: A read of 16'h4016 pulls `win_rd_n[22]` low and a read of 16'h4017 pulls `win_rd_n[23]` low, in both modes. In test mode these reads return 8'h00 instead of `ext_bus_in`.
- R6: A write (`rw`=0) to 16'h4000+i with `phi2` high pulls `win_wr_n[i]` low and leaves the other bits high. A read does the same on `win_rd_n[i]`. The exception is offsets 24 to 26, whose strobes stay high in normal mode. The controller write strobe `win_wr_n[22]` behaves the same in both modes.
- R7: In test mode, a write to offset 24+k with `phi2` high stores `wr_data` in test register k on that clock edge, and a test-mode read of that offset returns it. A write made in normal mode, or made while `phi2` is low, leaves the register unchanged.
- R8: In test mode, a read of any window offset other than 16'h15 and 24 to 26 returns 8'h00.
- R9: A change on `test_pin` reaches the decode after exactly two rising clock edges. Reset forces normal mode and clears the test registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Core address |
| rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | Access phase; strobes act only while high |
| test_pin | input | 1 | Raw test-mode pin |
| wr_data | input | 8 | Write data for the test registers |
| status_in | input | 8 | Value of the status register at offset 16'h15 |
| ext_bus_in | input | 8 | Byte read from the external data pins |
| win_rd_n | output | 32 | Active-low read strobe per window offset |
| win_wr_n | output | 32 | Active-low write strobe per window offset |
| data_oe | output | 1 | Data pins driven by the chip |
| cpu_rd_data | output | 8 | Byte returned to the core |

## Verification
The hardest case to reach from the ports is the exact edge at which the conditioned test mode takes over. It lies two clock edges after the pin moves, while an access is being held on the bus. The bench raises the pin on a falling edge and holds a window read steady. It then checks that `data_oe` is still low after the first rising edge and high after the second. Test-register retention is another state the ports hide in normal mode. To check it, the bench writes in normal mode and while `phi2` is low, then switches to test mode and reads the registers back.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int WIN_LOG2 = 5;
  localparam int WIN_SIZE = 1 << WIN_LOG2;
  localparam int TREG_NUM = 3;
  localparam int COND_STAGES = 2;

  localparam logic [ADDR_W-1:0]   WIN_BASE   = 16'h4000;
  localparam logic [WIN_LOG2-1:0] STATUS_OFF = 5'h15;
  localparam logic [WIN_LOG2-1:0] TREG_FIRST = 5'h18;
  localparam logic [WIN_LOG2-1:0] TREG_LAST  = TREG_FIRST + WIN_LOG2'(TREG_NUM - 1);

  typedef logic [WIN_LOG2-1:0] win_off_t;
  typedef logic [DATA_W-1:0]   byte_t;

  function automatic logic in_window(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2];
  endfunction

  function automatic logic is_treg(win_off_t off);
    return (off >= TREG_FIRST) && (off <= TREG_LAST);
  endfunction

  // Offset answered from inside the chip for the given mode
  function automatic logic is_internal(win_off_t off, logic test_mode);
    return test_mode || (off == STATUS_OFF);
  endfunction

  // Strobe is allowed for this offset in the given mode
  function automatic logic strobe_allowed(win_off_t off, logic test_mode);
    return test_mode || !is_treg(off);
  endfunction
endpackage

// File: rtl/pin_cond.sv
module pin_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);
  // Each stage stores the complement of its input; stage 0 inverts the pin,
  // the last output is inverted once more when STAGES is odd.
  logic [STAGES-1:0] st;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic nxt;
      if (s == 0) begin : g_first
        assign nxt = ~pin;
      end else begin : g_rest
        assign nxt = ~st[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= ((s % 2) == 0);
        else        st[s] <= nxt;
      end
    end
  endgenerate

  generate
    if ((STAGES % 2) == 0) begin : g_even
      assign level = st[STAGES-1];
    end else begin : g_odd
      assign level = ~st[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import io_dec_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rw,
  input  logic                phi2,
  input  logic                test_mode,
  output win_off_t            offset,
  output logic                hit,
  output logic                int_rd,
  output logic [WIN_SIZE-1:0] win_rd_n,
  output logic [WIN_SIZE-1:0] win_wr_n,
  output logic                data_oe
);
  logic rd_act, wr_act;

  assign offset = addr[WIN_LOG2-1:0];
  assign hit    = in_window(addr);
  assign rd_act = hit && phi2 && rw;
  assign wr_act = hit && phi2 && !rw;
  assign int_rd = hit && rw && is_internal(offset, test_mode);
  assign data_oe = int_rd && phi2;

  generate
    for (genvar i = 0; i < WIN_SIZE; i++) begin : g_strobe
      localparam win_off_t OFF = win_off_t'(i);
      logic sel;
      assign sel = (offset == OFF) && strobe_allowed(OFF, test_mode);
      assign win_rd_n[i] = ~(rd_act && sel);
      assign win_wr_n[i] = ~(wr_act && sel);
    end
  endgenerate
endmodule

// File: rtl/test_regs.sv
module test_regs
  import io_dec_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TREG_NUM-1:0]        wr_n,
  input  byte_t                      wr_data,
  output logic [TREG_NUM*DATA_W-1:0] q
);
  generate
    for (genvar k = 0; k < TREG_NUM; k++) begin : g_reg
      byte_t r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      r <= '0;
        else if (!wr_n[k]) r <= wr_data;
      end
      assign q[k*DATA_W +: DATA_W] = r;
    end
  endgenerate
endmodule

// File: rtl/io_window_decode.sv
module io_window_decode
  import io_dec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [15:0]         addr,
  input  logic                rw,
  input  logic                phi2,
  input  logic                test_pin,
  input  logic [7:0]          wr_data,
  input  logic [7:0]          status_in,
  input  logic [7:0]          ext_bus_in,
  output logic [31:0]         win_rd_n,
  output logic [31:0]         win_wr_n,
  output logic                data_oe,
  output logic [7:0]          cpu_rd_data
);
  logic                       test_mode;
  win_off_t                   offset;
  logic                       hit;
  logic                       int_rd;
  logic [TREG_NUM*DATA_W-1:0] treg_q;
  byte_t                      int_val;

  pin_cond #(.STAGES(COND_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .pin(test_pin), .level(test_mode)
  );

  addr_decode u_dec (
    .addr(addr), .rw(rw), .phi2(phi2), .test_mode(test_mode),
    .offset(offset), .hit(hit), .int_rd(int_rd),
    .win_rd_n(win_rd_n), .win_wr_n(win_wr_n), .data_oe(data_oe)
  );

  test_regs u_treg (
    .clk(clk), .rst_n(rst_n),
    .wr_n(win_wr_n[TREG_FIRST +: TREG_NUM]),
    .wr_data(wr_data), .q(treg_q)
  );

  always_comb begin
    int_val = '0;
    if (offset == STATUS_OFF) int_val = status_in;
    for (int k = 0; k < TREG_NUM; k++) begin
      if (offset == TREG_FIRST + win_off_t'(k))
        int_val = treg_q[k*DATA_W +: DATA_W];
    end
  end

  assign cpu_rd_data = int_rd ? int_val : ext_bus_in;
endmodule

// File: rtl/io_window_decode_chk.sv
module io_window_decode_chk
  import io_dec_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          addr,
  input logic                       rw,
  input logic                       phi2,
  input logic                       test_pin,
  input logic                       test_mode,
  input logic [WIN_SIZE-1:0]        win_rd_n,
  input logic [WIN_SIZE-1:0]        win_wr_n,
  input logic                       data_oe,
  input byte_t                      cpu_rd_data,
  input logic [TREG_NUM*DATA_W-1:0] treg_q
);
  logic inwin;
  assign inwin = in_window(addr);

  assert_outside_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inwin |-> (&win_rd_n) && (&win_wr_n) && !data_oe);

  assert_phi2_low_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |-> (&win_rd_n) && (&win_wr_n) && !data_oe);

  assert_normal_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && data_oe) |-> (addr == 16'h4015) && rw);

  assert_test_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && inwin && phi2 && rw) |-> data_oe);

  assert_pad_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && rw && (addr == 16'h4016 || addr == 16'h4017)) |-> cpu_rd_data == '0);

  assert_treg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (&win_rd_n[TREG_FIRST +: TREG_NUM]) && (&win_wr_n[TREG_FIRST +: TREG_NUM]));

  assert_treg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> $stable(treg_q));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~win_rd_n) + $countones(~win_wr_n) <= 1);

  assert_test_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> $past(test_pin, 2));
endmodule

bind io_window_decode io_window_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .phi2(phi2),
  .test_pin(test_pin), .test_mode(test_mode), .win_rd_n(win_rd_n),
  .win_wr_n(win_wr_n), .data_oe(data_oe), .cpu_rd_data(cpu_rd_data),
  .treg_q(treg_q)
);

// File: tb/test_io_window_decode.sv
`timescale 1ns/1ps
module test_io_window_decode;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] addr = 16'h0000;
  logic        rw = 1;
  logic        phi2 = 0;
  logic        test_pin = 0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  status_in = 8'hA5;
  logic [7:0]  ext_bus_in = 8'h3C;
  logic [31:0] win_rd_n, win_wr_n;
  logic        data_oe;
  logic [7:0]  cpu_rd_data;

  int total = 0;
  int bad = 0;
  logic [7:0] model_treg [3];
  logic       mode_now = 0;

  always #2 clk = ~clk;

  io_window_decode i_io_window_decode (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .phi2(phi2),
    .test_pin(test_pin), .wr_data(wr_data), .status_in(status_in),
    .ext_bus_in(ext_bus_in), .win_rd_n(win_rd_n), .win_wr_n(win_wr_n),
    .data_oe(data_oe), .cpu_rd_data(cpu_rd_data)
  );

  // {test, rw, phi2, addr[15:0], exp_oe, exp_data[7:0]}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 16'h4015, 1'b1, 8'hA5},
    {1'b0, 1'b1, 1'b1, 16'h4016, 1'b0, 8'h3C},
    {1'b1, 1'b1, 1'b1, 16'h4016, 1'b1, 8'h00},
    {1'b1, 1'b1, 1'b1, 16'h4017, 1'b1, 8'h00},
    {1'b1, 1'b1, 1'b1, 16'h4015, 1'b1, 8'hA5},
    {1'b0, 1'b1, 1'b0, 16'h4015, 1'b0, 8'hA5},
    {1'b1, 1'b1, 1'b1, 16'h401F, 1'b1, 8'h00},
    {1'b1, 1'b1, 1'b1, 16'h3FFF, 1'b0, 8'h3C},
    {1'b1, 1'b1, 1'b1, 16'h4020, 1'b0, 8'h3C},
    {1'b0, 1'b0, 1'b1, 16'h4015, 1'b0, 8'h3C},
    {1'b1, 1'b0, 1'b1, 16'h4018, 1'b0, 8'h3C}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic win(logic [15:0] a);
    return a >= 16'h4000 && a <= 16'h401F;
  endfunction

  function automatic logic [31:0] exp_strobe(logic t, logic p, logic want, logic [15:0] a);
    logic [31:0] v = '1;
    int o = int'(a) - 16'h4000;
    if (p && want && win(a) && (t || o < 24 || o > 26)) v[o] = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] exp_data(logic t, logic r, logic [15:0] a);
    int o = int'(a) - 16'h4000;
    if (!(r && win(a) && (t || o == 21))) return ext_bus_in;
    if (o == 21) return status_in;
    if (o >= 24 && o <= 26) return model_treg[o-24];
    return 8'h00;
  endfunction

  task automatic set_mode(logic t);
    @(negedge clk);
    phi2 = 0;
    test_pin = t;
    repeat (3) @(posedge clk);
    mode_now = t;
  endtask

  task automatic apply(logic r, logic p, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    rw = r; phi2 = p; addr = a; wr_data = d;
    #1;
  endtask

  task automatic full_check(string req);
    check({req, " rd strobes"}, win_rd_n, exp_strobe(mode_now, phi2, rw, addr));
    check({req, " wr strobes"}, win_wr_n, exp_strobe(mode_now, phi2, !rw, addr));
    check({req, " oe"}, {31'd0, data_oe},
          {31'd0, phi2 && rw && win(addr) && (mode_now || addr == 16'h4015)});
    check({req, " data"}, {24'd0, cpu_rd_data}, {24'd0, exp_data(mode_now, rw, addr)});
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) model_treg[k] = 8'h00;
    // Reset state with the pin high: normal mode held (R9)
    test_pin = 1;
    rw = 1; phi2 = 1; addr = 16'h4000;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    check("R9 reset forces normal oe", {31'd0, data_oe}, 32'd0);
    check("R4 reset rd strobe", win_rd_n, exp_strobe(1'b0, 1'b1, 1'b1, 16'h4000));
    rst_n = 1;
    set_mode(0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v = VEC[i];
      if (v[27] != mode_now) set_mode(v[27]);
      apply(v[26], v[25], v[24:9], 8'h00);
      check($sformatf("R3/R5 vec%0d oe", i), {31'd0, data_oe}, {31'd0, v[8]});
      check($sformatf("R1/R8 vec%0d data", i), {24'd0, cpu_rd_data}, {24'd0, v[7:0]});
    end

    // Sweep of the window plus neighbours in both modes, both directions
    for (int t = 0; t < 2; t++) begin
      set_mode(t[0]);
      for (int r = 0; r < 2; r++) begin
        for (int a = 16'h3FFE; a <= 16'h4021; a++) begin
          apply(r[0], 1'b1, a[15:0], 8'h00);
          full_check("R1/R4/R6/R8 sweep");
        end
        apply(r[0], 1'b0, 16'h4016, 8'h00);
        full_check("R2 phi2 low");
      end
    end

    // Controller strobes and write port in both modes (R5, R6)
    for (int t = 0; t < 2; t++) begin
      set_mode(t[0]);
      apply(1'b1, 1'b1, 16'h4017, 8'h00);
      check("R5 pad1 read strobe", {31'd0, win_rd_n[23]}, 32'd0);
      apply(1'b0, 1'b1, 16'h4016, 8'h00);
      check("R6 pad write strobe", {31'd0, win_wr_n[22]}, 32'd0);
    end

    // Test register storage (R7)
    set_mode(1);
    apply(1'b0, 1'b1, 16'h4019, 8'h5A);
    model_treg[1] = 8'h5A;
    apply(1'b1, 1'b1, 16'h4019, 8'h00);
    check("R7 treg readback", {24'd0, cpu_rd_data}, 32'h5A);
    apply(1'b0, 1'b0, 16'h401A, 8'h77);
    apply(1'b1, 1'b1, 16'h401A, 8'h00);
    check("R7 phi2-low write ignored", {24'd0, cpu_rd_data}, 32'h00);
    set_mode(0);
    apply(1'b0, 1'b1, 16'h4018, 8'hFF);
    check("R6 treg wr strobe blocked", {31'd0, win_wr_n[24]}, 32'd1);
    set_mode(1);
    apply(1'b1, 1'b1, 16'h4018, 8'h00);
    check("R7 normal-mode write ignored", {24'd0, cpu_rd_data}, 32'h00);
    apply(1'b1, 1'b1, 16'h4019, 8'h00);
    check("R7 treg retained", {24'd0, cpu_rd_data}, 32'h5A);

    // Conditioning latency (R9)
    set_mode(0);
    apply(1'b1, 1'b1, 16'h4000, 8'h00);
    test_pin = 1;
    @(posedge clk); @(negedge clk); #1;
    check("R9 one edge still normal", {31'd0, data_oe}, 32'd0);
    @(posedge clk); @(negedge clk); #1;
    check("R9 two edges test mode", {31'd0, data_oe}, 32'd1);
    mode_now = 1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule